// File: doc/BRIEF.md
# Accumulator ALU with Status Word

This block is the arithmetic and logic stage of an 8-bit accumulator datapath. On each cycle it takes the accumulator byte, a second operand byte and a 5-bit operation select. From these it forms a result at once, in combinational logic, and raises a write strobe when that result should go back to its destination. Routing the destination is the surrounding datapath's job. When the enable is high, the 5-bit status word is updated at the clock edge. Four of its bits are condition flags and one is an interrupt-enable bit.

Each class of operation follows its own flag rule. Shifts and the bitwise operations clear overflow and carry. Binary and decimal additions, the decrement and the compare set all four flags from the adder. The status-control operations leave the flags alone and only set, clear or load the status word. A single adder serves every arithmetic operation; its operands are multiplexed per operation. A per-digit correction stage built on that adder produces the decimal sum.

There is no control state machine. The status word is the only state, and there are two conditions: idle when the enable is low, and update when it is high. In update, the select picks one of four transitions of the status word: a flag update, an interrupt-bit set or clear, a full load, or a hold for unassigned codes.

Top module: `acc_alu`

## Requirements
- R1: The status word bit layout is bit 0 sign, bit 1 carry, bit 2 zero, bit 3 overflow and bit 4 interrupt enable. Reset (rst_n low) clears all five bits.
- R2: Right shift by one (code 0) and by four (code 2) shift the accumulator right and fill with zeros. They write the result, clear overflow and carry, set sign to 1 and set zero from the result.
- R3: Left shift by one (code 1) and by four (code 3) shift the accumulator left and fill with zeros. They write the result, clear overflow and carry, and set zero and sign from the result.
- R4: Complement of the accumulator (code 4), AND (code 5), OR (code 6), XOR (code 7) with the operand, and input pass of the operand (code 14) all write the result. They clear overflow and carry and set zero and sign from the result.
- R5: For every flag-updating operation, zero is 1 exactly when the 8-bit result is 0, and sign is 1 exactly when result bit 7 is 0.
- R6: Add (code 8: accumulator plus operand), add-carry (code 9: accumulator plus the current carry flag) and increment (code 10: accumulator plus 1) write the 8-bit sum. Carry is the carry out of bit 7, and overflow is the XOR of the carries into and out of bit 7.
- R7: Decrement (code 11) writes the operand plus 0xFF, with carry and overflow as in R6.
- R8: Compare (code 13) forms the operand minus the accumulator as operand + ~accumulator + 1. It sets all four flags from that sum by the rule of R6 and R5, and does not raise the write strobe.
- R9: Decimal add (code 12) adds two valid BCD bytes. It writes the BCD sum modulo 100, sets carry when the decimal sum is 100 or more, sets overflow from the binary sum as in R6, and sets zero and sign from the written result.
- R10: Interrupt-off (code 15) clears bit 4 and interrupt-on (code 16) sets it. Both leave bits 3..0 unchanged and do not write a result. Every other operation leaves bit 4 unchanged.
- R11: Status load (code 17) replaces all five status bits with operand bits 4..0 and does not write a result.
- R12: When the enable is low, the status word holds and the write strobe is low. Codes 18 to 31 change nothing and do not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Execute the selected operation this cycle |
| op_sel | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator byte |
| opnd_in | input | 8 | Second operand (immediate, memory or scratchpad byte) |
| result | output | 8 | Combinational result |
| result_we | output | 1 | Result should be written back |
| status | output | 5 | Registered status word |

## Verification
The hardest case to reach is an add-carry whose carry-in comes from the flag left by an earlier operation. It is only correct if the flag written in one cycle is the one the adder reads in the next. The stimulus sets up this chain on purpose: overflowing adds, decrements of zero and equal compares each leave a known carry before an add-carry. A long random sequence then mixes all codes, with the enable dropping at random, so that carry and the interrupt bit pass through every kind of operation. Decimal adds use only valid BCD operands, including the 99 + 01 wrap.

// File: rtl/accalu_pkg.sv
package accalu_pkg;
    localparam int DATA_W  = 8;
    localparam int STAT_W  = 5;
    localparam int OPSEL_W = 5;

    localparam int SB_SIGN  = 0;
    localparam int SB_CARRY = 1;
    localparam int SB_ZERO  = 2;
    localparam int SB_OVF   = 3;
    localparam int SB_IEN   = 4;

    typedef enum logic [OPSEL_W-1:0] {
        OP_SHR1   = 5'd0,
        OP_SHL1   = 5'd1,
        OP_SHR4   = 5'd2,
        OP_SHL4   = 5'd3,
        OP_CPL    = 5'd4,
        OP_AND    = 5'd5,
        OP_OR     = 5'd6,
        OP_XOR    = 5'd7,
        OP_ADD    = 5'd8,
        OP_ADDC   = 5'd9,
        OP_INC    = 5'd10,
        OP_DEC    = 5'd11,
        OP_DADD   = 5'd12,
        OP_CMP    = 5'd13,
        OP_IN     = 5'd14,
        OP_INTOFF = 5'd15,
        OP_INTON  = 5'd16,
        OP_LDSTAT = 5'd17
    } alu_op_e;
endpackage

// File: rtl/accalu_bcd.sv
module accalu_bcd #(
    parameter int DIGITS = 2
) (
    input  logic [4*DIGITS-1:0] a,
    input  logic [4*DIGITS-1:0] b,
    output logic [4*DIGITS-1:0] sum,
    output logic                carry
);
    logic [DIGITS:0] dc;
    assign dc[0] = 1'b0;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [4:0] raw;
        logic       fix;
        logic [3:0] adj;
        assign raw = {1'b0, a[4*g+:4]} + {1'b0, b[4*g+:4]} + {4'b0, dc[g]};
        assign fix = (raw > 5'd9);
        assign adj = raw[3:0] + (fix ? 4'd6 : 4'd0);
        assign sum[4*g+:4] = adj;
        assign dc[g+1] = fix;
    end

    assign carry = dc[DIGITS];
endmodule

// File: rtl/accalu_core.sv
module accalu_core
    import accalu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin_flag,
    output logic [DW-1:0] res,
    output logic          wr,
    output logic          upd,
    output logic          f_ovf,
    output logic          f_zero,
    output logic          f_carry,
    output logic          f_sign
);
    localparam int DIGITS = DW / 4;

    logic [DW-1:0] x, y;
    logic          ci;
    logic [DW:0]   sum;
    logic          c_into_msb;
    logic [DW-1:0] bcd_sum;
    logic          bcd_c;
    logic          arith, dec;

    accalu_bcd #(.DIGITS(DIGITS)) u_bcd (
        .a     (a),
        .b     (b),
        .sum   (bcd_sum),
        .carry (bcd_c)
    );

    // adder operand selection
    always_comb begin
        x  = a;
        y  = '0;
        ci = 1'b0;
        case (op)
            OP_ADD, OP_DADD: y = b;
            OP_ADDC:         ci = cin_flag;
            OP_INC:          ci = 1'b1;
            OP_DEC: begin
                x = b;
                y = '1;
            end
            OP_CMP: begin
                x  = b;
                y  = ~a;
                ci = 1'b1;
            end
            default: ;
        endcase
    end

    assign sum        = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
    assign c_into_msb = sum[DW-1] ^ x[DW-1] ^ y[DW-1];

    // result and flag policy
    always_comb begin
        res   = '0;
        wr    = 1'b0;
        upd   = 1'b0;
        arith = 1'b0;
        dec   = 1'b0;
        case (op)
            OP_SHR1: begin res = a >> 1; wr = 1'b1; upd = 1'b1; end
            OP_SHL1: begin res = a << 1; wr = 1'b1; upd = 1'b1; end
            OP_SHR4: begin res = a >> 4; wr = 1'b1; upd = 1'b1; end
            OP_SHL4: begin res = a << 4; wr = 1'b1; upd = 1'b1; end
            OP_CPL:  begin res = ~a;     wr = 1'b1; upd = 1'b1; end
            OP_AND:  begin res = a & b;  wr = 1'b1; upd = 1'b1; end
            OP_OR:   begin res = a | b;  wr = 1'b1; upd = 1'b1; end
            OP_XOR:  begin res = a ^ b;  wr = 1'b1; upd = 1'b1; end
            OP_IN:   begin res = b;      wr = 1'b1; upd = 1'b1; end
            OP_ADD, OP_ADDC, OP_INC, OP_DEC: begin
                res = sum[DW-1:0]; wr = 1'b1; upd = 1'b1; arith = 1'b1;
            end
            OP_CMP: begin
                res = sum[DW-1:0]; upd = 1'b1; arith = 1'b1;
            end
            OP_DADD: begin
                res = bcd_sum; wr = 1'b1; upd = 1'b1; arith = 1'b1; dec = 1'b1;
            end
            default: ;
        endcase
    end

    assign f_zero  = (res == '0);
    assign f_sign  = ~res[DW-1];
    assign f_carry = arith & (dec ? bcd_c : sum[DW]);
    assign f_ovf   = arith & (sum[DW] ^ c_into_msb);
endmodule

// File: rtl/accalu_status.sv
module accalu_status
    import accalu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  alu_op_e           op,
    input  logic [STAT_W-1:0] ld_val,
    input  logic              upd,
    input  logic              f_ovf,
    input  logic              f_zero,
    input  logic              f_carry,
    input  logic              f_sign,
    output logic [STAT_W-1:0] w
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w <= '0;
        end else if (en) begin
            if (op == OP_LDSTAT) begin
                w <= ld_val;
            end else if (op == OP_INTOFF) begin
                w[SB_IEN] <= 1'b0;
            end else if (op == OP_INTON) begin
                w[SB_IEN] <= 1'b1;
            end else if (upd) begin
                w[SB_OVF]   <= f_ovf;
                w[SB_ZERO]  <= f_zero;
                w[SB_CARRY] <= f_carry;
                w[SB_SIGN]  <= f_sign;
            end
        end
    end

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(w));

    // R10
    ien_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_INTON) |=> w[SB_IEN]);

    // R10
    ien_flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (op == OP_INTON || op == OP_INTOFF)) |=> (w[3:0] == $past(w[3:0])));

    // R4
    logic_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_CPL))
        |=> (!w[SB_OVF] && !w[SB_CARRY]));

    // R2
    shr_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (op == OP_SHR1 || op == OP_SHR4)) |=> w[SB_SIGN]);
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import accalu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_en,
    input  logic [OPSEL_W-1:0] op_sel,
    input  logic [DATA_W-1:0]  acc_in,
    input  logic [DATA_W-1:0]  opnd_in,
    output logic [DATA_W-1:0]  result,
    output logic               result_we,
    output logic [STAT_W-1:0]  status
);
    alu_op_e op;
    logic    wr, upd, f_ovf, f_zero, f_carry, f_sign;

    assign op = alu_op_e'(op_sel);

    accalu_core #(.DW(DATA_W)) u_core (
        .op       (op),
        .a        (acc_in),
        .b        (opnd_in),
        .cin_flag (status[SB_CARRY]),
        .res      (result),
        .wr       (wr),
        .upd      (upd),
        .f_ovf    (f_ovf),
        .f_zero   (f_zero),
        .f_carry  (f_carry),
        .f_sign   (f_sign)
    );

    accalu_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (op_en),
        .op      (op),
        .ld_val  (opnd_in[STAT_W-1:0]),
        .upd     (upd),
        .f_ovf   (f_ovf),
        .f_zero  (f_zero),
        .f_carry (f_carry),
        .f_sign  (f_sign),
        .w       (status)
    );

    assign result_we = op_en & wr;

    // R8
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 5'd13) |-> !result_we);
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_en;
    logic [4:0] op_sel;
    logic [7:0] acc_in, opnd_in;
    logic [7:0] result;
    logic       result_we;
    logic [4:0] status;

    int n_chk  = 0;
    int n_fail = 0;
    int mw     = 0;
    string last_tag = "R1";

    always #5 clk = ~clk;

    acc_alu dut (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel),
        .acc_in(acc_in), .opnd_in(opnd_in),
        .result(result), .result_we(result_we), .status(status)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // returns res | carry<<8 | ovf<<9
    function automatic int addf(input int x, input int y, input int ci);
        int t  = x + y + ci;
        int t7 = (x & 127) + (y & 127) + ci;
        int c  = (t > 255) ? 1 : 0;
        int c7 = (t7 > 127) ? 1 : 0;
        return (t & 255) | (c << 8) | ((c ^ c7) << 9);
    endfunction

    function automatic int bcd_val(input int v);
        return (v >> 4) * 10 + (v & 15);
    endfunction

    task automatic run_op(input int op, input int a, input int b, input bit e);
        int r = 0, o = 0, c = 0, pk;
        bit we = 0, fl = 0;
        int nw;
        string tag;
        @(negedge clk);
        chk(status == mw[4:0], {last_tag, " status"}, status, mw);
        op_sel = op[4:0]; acc_in = a[7:0]; opnd_in = b[7:0]; op_en = e;
        nw = mw;
        tag = "R12";
        case (op)
            0:  begin r = a >> 1;          we = 1; fl = 1; tag = "R2"; end
            2:  begin r = a >> 4;          we = 1; fl = 1; tag = "R2"; end
            1:  begin r = (a << 1) & 255;  we = 1; fl = 1; tag = "R3"; end
            3:  begin r = (a << 4) & 255;  we = 1; fl = 1; tag = "R3"; end
            4:  begin r = (~a) & 255;      we = 1; fl = 1; tag = "R4"; end
            5:  begin r = a & b;           we = 1; fl = 1; tag = "R4"; end
            6:  begin r = a | b;           we = 1; fl = 1; tag = "R4"; end
            7:  begin r = a ^ b;           we = 1; fl = 1; tag = "R4"; end
            14: begin r = b;               we = 1; fl = 1; tag = "R4"; end
            8:  begin pk = addf(a, b, 0);  we = 1; fl = 1; tag = "R6"; end
            9:  begin pk = addf(a, 0, (mw >> 1) & 1); we = 1; fl = 1; tag = "R6"; end
            10: begin pk = addf(a, 1, 0);  we = 1; fl = 1; tag = "R6"; end
            11: begin pk = addf(b, 255, 0); we = 1; fl = 1; tag = "R7"; end
            13: begin pk = addf(b, (~a) & 255, 1); fl = 1; tag = "R8"; end
            12: begin
                int d = bcd_val(a) + bcd_val(b);
                pk = addf(a, b, 0);
                o = (pk >> 9) & 1;
                c = (d >= 100) ? 1 : 0;
                r = (((d % 100) / 10) << 4) | (d % 10);
                we = 1; fl = 1; tag = "R9";
            end
            15: begin nw = mw & 15;              tag = "R10"; end
            16: begin nw = mw | 16;              tag = "R10"; end
            17: begin nw = b & 31;               tag = "R11"; end
            default: ;
        endcase
        if (op inside {8, 9, 10, 11, 13}) begin
            r = pk & 255; c = (pk >> 8) & 1; o = (pk >> 9) & 1;
        end
        if (fl)
            nw = (mw & 16) | (o << 3) | ((r == 0 ? 1 : 0) << 2) | (c << 1) | (r < 128 ? 1 : 0);
        if (!e) begin
            nw = mw; we = 0; tag = "R12";
        end
        #1;
        chk(result_we == we, {tag, " write strobe"}, result_we, we);
        if (we) chk(result == r[7:0], {tag, " result"}, result, r);
        mw = nw;
        last_tag = (tag == "R12" || !fl) ? tag : {tag, "/R5"};
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_en = 1'b0; op_sel = '0; acc_in = '0; opnd_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(status == 5'd0, "R1 reset status", status, 0);
        rst_n = 1'b1;
        // R11 full load, then R10 interrupt control
        run_op(17, 8'h00, 8'hFF, 1);
        run_op(15, 8'h00, 8'h00, 1);
        run_op(16, 8'h00, 8'h00, 1);
        // R6 overflow and carry corners
        run_op(8, 8'h7F, 8'h01, 1);
        run_op(8, 8'hFF, 8'h01, 1);
        run_op(9, 8'h10, 8'h00, 1);
        run_op(9, 8'h10, 8'h00, 1);
        run_op(10, 8'hFF, 8'h00, 1);
        // R7 decrement wrap and to zero
        run_op(11, 8'h00, 8'h00, 1);
        run_op(9, 8'h20, 8'h00, 1);
        run_op(11, 8'h00, 8'h01, 1);
        run_op(11, 8'h00, 8'h80, 1);
        // R8 compare equal, greater, less
        run_op(13, 8'h42, 8'h42, 1);
        run_op(9, 8'h01, 8'h00, 1);
        run_op(13, 8'h42, 8'h10, 1);
        run_op(13, 8'h10, 8'h42, 1);
        // R9 decimal
        run_op(12, 8'h99, 8'h01, 1);
        run_op(12, 8'h45, 8'h38, 1);
        run_op(12, 8'h50, 8'h50, 1);
        // R2 / R3 shifts
        run_op(0, 8'h81, 8'h00, 1);
        run_op(2, 8'hF0, 8'h00, 1);
        run_op(1, 8'h80, 8'h00, 1);
        run_op(3, 8'h0F, 8'h00, 1);
        // R4 logic and input pass
        run_op(4, 8'hFF, 8'h00, 1);
        run_op(5, 8'hF0, 8'h0F, 1);
        run_op(6, 8'h80, 8'h01, 1);
        run_op(7, 8'hAA, 8'hAA, 1);
        run_op(14, 8'h00, 8'h9C, 1);
        // R12 idle and unassigned codes
        run_op(8, 8'hFF, 8'h01, 0);
        run_op(20, 8'h00, 8'h00, 1);
        run_op(31, 8'hFF, 8'hFF, 1);
        // mixed random sequence
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 21);
            int a  = $urandom_range(0, 255);
            int b  = $urandom_range(0, 255);
            bit e  = ($urandom_range(0, 7) != 0);
            if (op == 12) begin
                a = ($urandom_range(0, 9) << 4) | $urandom_range(0, 9);
                b = ($urandom_range(0, 9) << 4) | $urandom_range(0, 9);
            end
            run_op(op, a, b, e);
        end
        @(negedge clk);
        chk(status == mw[4:0], {last_tag, " status"}, status, mw);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule